// File: doc/BRIEF.md
# Three-Bus Register Add Sequencer

This block steps a small processor datapath through the fetch of one instruction word and the execution of a three-register add. The datapath has three buses. Buses A and B feed the ALU, and bus C carries the ALU result back to the registers. The register file has two read ports, which drive buses A and B, and one write port, which is fed from bus C. The program counter has its own incrementer, so fetch does not need the ALU to advance it. The ALU can also pass bus B straight through, which lets the PC and the memory data register reach their destinations without a temporary register. As a result an instruction takes four steps: fetch, memory wait, instruction load and execute.

Every instruction word is treated as a register-to-register add. While `run_i` is low the sequencer rests in a halted state. In that state the operand load port may preset any register, and the bench reads registers back through the write-back port by adding them to register zero.

The states and their transitions are as follows:
- **HALT** goes to **FETCH** when `run_i` is high.
- **FETCH** (step 1) always goes to **WAIT**.
- **WAIT** (step 2) stays in **WAIT** until `mem_done_i` is high, then goes to **DECODE**.
- **DECODE** (step 3) always goes to **EXEC**.
- **EXEC** (step 4) goes to **FETCH** if `run_i` is high, or to **HALT** if it is low.

Top module: `tbus_add_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, the block is in HALT: `mem_rd_o`, `step_end_o` and `wb_en_o` are low. The first fetch after reset reads address RESET_PC, which is 0 by default.
- R2: In HALT with `run_i` low, the block stays halted. A load strobe (`ld_en_i`) writes `ld_val_i` into register `ld_idx_i`.
- R3: FETCH lasts one cycle and asserts `mem_rd_o`. It copies the PC into the address register, so the copied value is on `mem_addr_o` from the next cycle on. It also advances the PC by PC_INC (4 by default), so consecutive fetches use addresses that differ by PC_INC.
- R4: WAIT keeps `mem_rd_o` high and `mem_addr_o` unchanged for every cycle in which `mem_done_i` is low. On the first cycle with `mem_done_i` high it captures `mem_rdata_i` and leaves WAIT.
- R5: DECODE lasts one cycle. It moves the captured word into the instruction register and asserts none of `mem_rd_o`, `wb_en_o` or `step_end_o`.
- R6: EXEC lasts one cycle and asserts `step_end_o` and `wb_en_o`. `wb_data_o` equals R[a] + R[b] modulo 2^DATA_W and `wb_idx_o` equals d, where the instruction word holds a in bits 25:21, b in bits 20:16 and d in bits 15:11. All other bits of the word are ignored.
- R7: After EXEC the next state is FETCH if `run_i` is high, and HALT if it is low.
- R8: Register 0 always reads as zero. A write to it, whether from an add or from the load port, has no effect.
- R9: A load strobe outside HALT is ignored.
- R10: A register written in EXEC holds its new value when the next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Allows instructions to start |
| ld_en_i | input | 1 | Operand load strobe, honoured only in HALT |
| ld_idx_i | input | 5 | Register index for the load strobe |
| ld_val_i | input | 32 | Value for the load strobe |
| mem_addr_o | output | 32 | Memory address register |
| mem_rd_o | output | 1 | Memory read request |
| mem_rdata_i | input | 32 | Memory read data |
| mem_done_i | input | 1 | Memory function complete |
| step_end_o | output | 1 | Last step of the instruction |
| wb_en_o | output | 1 | Register write on bus C |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Bus C value |

## Verification
The bench builds the block with its default parameters: 32-bit data, 32 registers and a PC step of 4. With 32-bit operands, sums that overflow and wrap (for example all-ones plus two) are easy to reach, and all 31 writable registers plus the hard-wired zero are covered by random field choices. Memory latency is drawn from zero to three wait cycles, so both an immediate completion and a stretched WAIT are exercised. The 32-bit address register lets the PC sequence be checked exactly over a few hundred fetches.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH,
        ST_WAIT,
        ST_DECODE,
        ST_EXEC
    } step_e;

    typedef enum logic [1:0] {
        ALU_ZERO,
        ALU_PASS_B,
        ALU_ADD
    } alu_op_e;

    typedef struct packed {
        logic    pc_to_b;
        logic    mdr_to_b;
        logic    rf_to_a;
        logic    rf_to_b;
        logic    sel_a;
        alu_op_e alu_op;
        logic    mar_load;
        logic    mem_rd;
        logic    pc_inc;
        logic    mdr_load;
        logic    ir_load;
        logic    rf_write;
        logic    ld_allow;
        logic    step_end;
    } ctrl_t;

endpackage

// File: rtl/tbus_seq_ctrl.sv
module tbus_seq_ctrl
    import tbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  logic  mem_done_i,
    output step_e state_o,
    output ctrl_t ctrl_o
);

    step_e state_q;
    step_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ctrl_o  = '0;
        unique case (state_q)
            ST_HALT: begin
                ctrl_o.ld_allow = 1'b1;
                if (run_i) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                ctrl_o.pc_to_b   = 1'b1;
                ctrl_o.alu_op    = ALU_PASS_B;
                ctrl_o.mar_load  = 1'b1;
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.pc_inc    = 1'b1;
                state_d          = ST_WAIT;
            end
            ST_WAIT: begin
                ctrl_o.mem_rd = 1'b1;
                if (mem_done_i) begin
                    ctrl_o.mdr_load = 1'b1;
                    state_d         = ST_DECODE;
                end
            end
            ST_DECODE: begin
                ctrl_o.mdr_to_b = 1'b1;
                ctrl_o.alu_op   = ALU_PASS_B;
                ctrl_o.ir_load  = 1'b1;
                state_d         = ST_EXEC;
            end
            ST_EXEC: begin
                ctrl_o.rf_to_a  = 1'b1;
                ctrl_o.rf_to_b  = 1'b1;
                ctrl_o.sel_a    = 1'b1;
                ctrl_o.alu_op   = ALU_ADD;
                ctrl_o.rf_write = 1'b1;
                ctrl_o.step_end = 1'b1;
                state_d         = run_i ? ST_FETCH : ST_HALT;
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tbus_regfile.sv
module tbus_regfile #(
    parameter int DATA_W  = 32,
    parameter int REG_CNT = 32,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] regs [REG_CNT];

    assign regs[0] = '0;

    for (genvar g = 1; g < REG_CNT; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];

endmodule

// File: rtl/tbus_alu.sv
module tbus_alu
    import tbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic              sel_a,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] opnd_a;

    assign opnd_a = sel_a ? bus_a : '0;

    always_comb begin
        unique case (op)
            ALU_PASS_B: result = bus_b;
            ALU_ADD:    result = opnd_a + bus_b;
            default:    result = '0;
        endcase
    end

endmodule

// File: rtl/tbus_add_seq.sv
module tbus_add_seq
    import tbus_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_CNT   = 32,
    parameter int PC_INC    = 4,
    parameter int RESET_PC  = 0,
    parameter int SRC_A_LSB = 21,
    parameter int SRC_B_LSB = 16,
    parameter int DST_LSB   = 11,
    localparam int IDX_W    = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              ld_en_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic [DATA_W-1:0] ld_val_i,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_done_i,
    output logic              step_end_o,
    output logic              wb_en_o,
    output logic [IDX_W-1:0]  wb_idx_o,
    output logic [DATA_W-1:0] wb_data_o
);

    step_e state;
    ctrl_t ctrl;

    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] bus_a;
    logic [DATA_W-1:0] bus_b;
    logic [DATA_W-1:0] bus_c;
    logic [DATA_W-1:0] rf_a_data;
    logic [DATA_W-1:0] rf_b_data;
    logic [IDX_W-1:0]  src_a_idx;
    logic [IDX_W-1:0]  src_b_idx;
    logic [IDX_W-1:0]  dst_idx;
    logic              ld_take;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_wa;
    logic [DATA_W-1:0] rf_wd;

    tbus_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .mem_done_i (mem_done_i),
        .state_o    (state),
        .ctrl_o     (ctrl)
    );

    assign src_a_idx = ir_q[SRC_A_LSB +: IDX_W];
    assign src_b_idx = ir_q[SRC_B_LSB +: IDX_W];
    assign dst_idx   = ir_q[DST_LSB +: IDX_W];

    assign ld_take = ld_en_i && ctrl.ld_allow;
    assign rf_we   = ctrl.rf_write || ld_take;
    assign rf_wa   = ctrl.rf_write ? dst_idx : ld_idx_i;
    assign rf_wd   = ctrl.rf_write ? bus_c : ld_val_i;

    tbus_regfile #(
        .DATA_W  (DATA_W),
        .REG_CNT (REG_CNT)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (src_a_idx),
        .rd_a_data (rf_a_data),
        .rd_b_idx  (src_b_idx),
        .rd_b_data (rf_b_data),
        .wr_en     (rf_we),
        .wr_idx    (rf_wa),
        .wr_data   (rf_wd)
    );

    assign bus_a = ctrl.rf_to_a ? rf_a_data : '0;

    always_comb begin
        bus_b = '0;
        if (ctrl.pc_to_b) begin
            bus_b = pc_q;
        end else if (ctrl.mdr_to_b) begin
            bus_b = mdr_q;
        end else if (ctrl.rf_to_b) begin
            bus_b = rf_b_data;
        end
    end

    tbus_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op     (ctrl.alu_op),
        .sel_a  (ctrl.sel_a),
        .bus_a  (bus_a),
        .bus_b  (bus_b),
        .result (bus_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= DATA_W'(RESET_PC);
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctrl.pc_inc) begin
                pc_q <= pc_q + DATA_W'(PC_INC);
            end
            if (ctrl.mar_load) begin
                mar_q <= bus_c;
            end
            if (ctrl.mdr_load) begin
                mdr_q <= mem_rdata_i;
            end
            if (ctrl.ir_load) begin
                ir_q <= bus_c;
            end
        end
    end

    assign mem_addr_o = mar_q;
    assign mem_rd_o   = ctrl.mem_rd;
    assign step_end_o = ctrl.step_end;
    assign wb_en_o    = ctrl.rf_write;
    assign wb_idx_o   = dst_idx;
    assign wb_data_o  = bus_c;

endmodule

// File: rtl/tbus_add_seq_chk.sv
module tbus_add_seq_chk
    import tbus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input step_e             state,
    input logic              run_i,
    input logic              mem_done_i,
    input logic              mem_rd_o,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic              step_end_o,
    input logic              wb_en_o,
    input logic              ld_take,
    input logic [IDX_W-1:0]  src_a_idx,
    input logic [DATA_W-1:0] rf_a_data
);

    // R3
    fetch_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> state == ST_WAIT && mem_rd_o);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !mem_done_i) |=> (state == ST_WAIT && mem_rd_o && $stable(mem_addr_o)));

    // R5
    decode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |-> !mem_rd_o && !wb_en_o && !step_end_o);

    // R7
    end_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_end_o && run_i) |=> state == ST_FETCH);

    // R7
    end_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_end_o && !run_i) |=> state == ST_HALT);

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_idx == '0 |-> rf_a_data == '0);

    // R9
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_take |-> state == ST_HALT && !wb_en_o);

endmodule

bind tbus_add_seq tbus_add_seq_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .run_i      (run_i),
    .mem_done_i (mem_done_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .step_end_o (step_end_o),
    .wb_en_o    (wb_en_o),
    .ld_take    (ld_take),
    .src_a_idx  (src_a_idx),
    .rf_a_data  (rf_a_data)
);

// File: tb/test_tbus_add_seq.sv
module test_tbus_add_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [4:0]  ld_idx_i = '0;
    logic [31:0] ld_val_i = '0;
    logic [31:0] mem_addr_o;
    logic        mem_rd_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_done_i = 1'b0;
    logic        step_end_o;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_data_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    int unsigned cycles = 0;
    logic [31:0] mdl [32];
    logic [31:0] exp_pc = 32'd0;

    always #10 clk = ~clk;

    tbus_add_seq i_tbus_add_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .ld_en_i     (ld_en_i),
        .ld_idx_i    (ld_idx_i),
        .ld_val_i    (ld_val_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_done_i  (mem_done_i),
        .step_end_o  (step_end_o),
        .wb_en_o     (wb_en_o),
        .wb_idx_o    (wb_idx_o),
        .wb_data_o   (wb_data_o)
    );

    function automatic logic [31:0] encode(input logic [4:0] d, input logic [4:0] a,
                                           input logic [4:0] b, input logic [31:0] junk);
        logic [31:0] w;
        w = junk & 32'hFC00_07FF;
        w[25:21] = a;
        w[20:16] = b;
        w[15:11] = d;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_reg(input logic [4:0] idx, input logic [31:0] val);
        ld_en_i  = 1'b1;
        ld_idx_i = idx;
        ld_val_i = val;
        @(negedge clk);
        ld_en_i = 1'b0;
        if (idx != 5'd0) mdl[idx] = val;
    endtask

    // Entered at a negedge in FETCH; leaves at the negedge after EXEC.
    task automatic run_instr(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                             input int delay, input logic next_run,
                             input logic poke, input logic [4:0] poke_idx);
        logic [31:0] sum;
        check("R3 fetch read", {31'd0, mem_rd_o}, 32'd1);
        @(negedge clk);
        check("R3 fetch address", mem_addr_o, exp_pc);
        exp_pc += 32'd4;
        if (poke) begin
            ld_en_i  = 1'b1;
            ld_idx_i = poke_idx;
            ld_val_i = 32'hBAD0_0BAD;
        end
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            ld_en_i = 1'b0;
            check("R4 wait read held", {31'd0, mem_rd_o}, 32'd1);
            check("R4 wait address held", mem_addr_o, exp_pc - 32'd4);
        end
        mem_rdata_i = encode(d, a, b, $urandom);
        mem_done_i  = 1'b1;
        @(negedge clk);
        ld_en_i     = 1'b0;
        mem_done_i  = 1'b0;
        mem_rdata_i = $urandom;
        check("R5 decode quiet", {29'd0, mem_rd_o, wb_en_o, step_end_o}, 32'd0);
        @(negedge clk);
        sum = mdl[a] + mdl[b];
        check("R6 end and write", {30'd0, wb_en_o, step_end_o}, 32'd3);
        check("R6 dest index", {27'd0, wb_idx_o}, {27'd0, d});
        check("R6 sum", wb_data_o, sum);
        if (d != 5'd0) mdl[d] = sum;
        run_i = next_run;
        @(negedge clk);
        check("R7 next step", {31'd0, mem_rd_o}, {31'd0, next_run});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'h1F2E_3D4C));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {29'd0, mem_rd_o, step_end_o, wb_en_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 halted after reset", {29'd0, mem_rd_o, step_end_o, wb_en_o}, 32'd0);

        // R2: preload in HALT, R8: load to register 0 is dropped
        for (int r = 1; r < 32; r++) load_reg(5'(r), $urandom);
        load_reg(5'd0, 32'hDEAD_BEEF);
        load_reg(5'd30, 32'hFFFF_FFFF);
        load_reg(5'd29, 32'd2);
        check("R2 still halted", {31'd0, mem_rd_o}, 32'd0);

        run_i = 1'b1;
        @(negedge clk);
        // R1: first fetch at address 0; R8: r0 + r0
        run_instr(5'd1, 5'd0, 5'd0, 0, 1'b1, 1'b0, 5'd0);
        // R6: wrap-around
        run_instr(5'd3, 5'd30, 5'd29, 2, 1'b1, 1'b0, 5'd0);
        // R8: add targeting register 0, then read it back
        run_instr(5'd0, 5'd4, 5'd5, 1, 1'b1, 1'b0, 5'd0);
        run_instr(5'd6, 5'd0, 5'd0, 0, 1'b1, 1'b0, 5'd0);
        // R10: read-after-write back to back
        run_instr(5'd5, 5'd3, 5'd2, 3, 1'b1, 1'b0, 5'd0);
        run_instr(5'd8, 5'd5, 5'd5, 0, 1'b1, 1'b0, 5'd0);
        // R9: load strobe while running is ignored; read r7 back
        run_instr(5'd9, 5'd1, 5'd2, 2, 1'b1, 1'b1, 5'd7);
        run_instr(5'd10, 5'd7, 5'd0, 0, 1'b0, 1'b0, 5'd0);

        // R7 halted; R2 load again, hold for a few cycles
        repeat (3) begin
            @(negedge clk);
            check("R2 halt holds", {31'd0, mem_rd_o}, 32'd0);
        end
        load_reg(5'd7, 32'h1234_5678);
        run_i = 1'b1;
        @(negedge clk);
        run_instr(5'd11, 5'd7, 5'd29, 1, 1'b1, 1'b0, 5'd0);

        for (int k = 0; k < 200; k++) begin
            run_instr(5'($urandom), 5'($urandom), 5'($urandom),
                      int'($urandom_range(0, 3)), 1'b1, 1'b0, 5'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule